// File: doc/BRIEF.md
# Serial Transmitter with Break Control

This block turns bytes into asynchronous serial frames. Software writes a character into a holding register; when the frame shifter is idle and a bit-rate tick arrives, the character moves into the shifter and goes out as a start bit, the data bits, an optional parity bit and one or two stop bits. The holding register then reads as empty again, so the next character can be queued while the current one is on the line.

The serial pin is shared with a small port register that holds a direction bit and a data bit. While transmission is disabled, the pin level comes from that port data bit. The output enable drops only when transmission is off and the port direction selects input. Turning transmission off resets the shifter on the next clock, even in the middle of a frame. To send a break, software clears the port data bit and then clears the transmit enable, which holds the pin low for as long as needed. A receive-error input blocks any new frame from starting while it is high.

Top module: `uart_tx_brk`

## Requirements
- R1: After reset `txd_o`=1, `txd_oe_o`=1, `tdr_empty_o`=1 and `tx_end_o`=1. The port register's direction and data bits both reset to 1.
- R2: While `tx_en_i`=0, `txd_o` equals the port data bit. A port write with `port_wr_i`=1 shows on `txd_o` one clock later.
- R3: `txd_oe_o`=0 exactly when `tx_en_i`=0 and the port direction bit is 0. Otherwise it is 1.
- R4: A frame is a start bit of 0, then the data bits LSB first, then the stop bits at 1. A frame only begins on a clock where `bit_tick_i`=1, and each bit lasts from one tick to the next.
- R5: With `word7_i`=1, only data bits [6:0] are sent. Bit 7 is neither sent nor counted in the parity.
- R6: With `par_en_i`=1, one parity bit follows the last data bit. `par_odd_i`=0 selects even parity: the data bits sent plus the parity bit hold an even number of ones. `par_odd_i`=1 makes that number odd.
- R7: `stop2_i`=1 sends two stop bits, and `stop2_i`=0 sends one.
- R8: After a write with `tdr_wr_i`=1, `tdr_empty_o` reads 0. It returns to 1 on the clock after the tick on which the shifter takes the character, which is the clock on which the start bit appears.
- R9: A character written while a frame is in flight starts on the tick that ends the last stop bit, with no idle bit between the two frames.
- R10: `tx_end_o` is 1 exactly when the shifter is idle and the holding register is empty.
- R11: Driving `tx_en_i` to 0 in the middle of a frame idles the shifter on the next clock. The pin follows the port data bit at once, and the aborted frame does not resume after re-enable.
- R12: Clearing the port data bit and then `tx_en_i` holds `txd_o` at 0 with `txd_oe_o`=1 (a break) until either bit changes.
- R13: While `rx_err_i`=1, no frame starts and a queued character stays in the holding register (`tdr_empty_o`=0). The character starts on the first tick after `rx_err_i` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-clock pulse per bit period |
| tx_en_i | input | 1 | Transmit enable. 0 resets the shifter |
| tdr_wr_i | input | 1 | Write strobe for the holding register |
| tdr_data_i | input | DATA_W | Character to transmit |
| tdr_empty_o | output | 1 | Holding register empty |
| word7_i | input | 1 | 1: seven data bits, 0: eight |
| par_en_i | input | 1 | Parity bit enable |
| par_odd_i | input | 1 | 1: odd parity, 0: even |
| stop2_i | input | 1 | 1: two stop bits |
| port_wr_i | input | 1 | Write strobe for the port register |
| port_dir_i | input | 1 | Port direction to write (1 = output) |
| port_dat_i | input | 1 | Port data bit to write |
| rx_err_i | input | 1 | Receive error pending. Blocks new frames |
| txd_o | output | 1 | Serial line level |
| txd_oe_o | output | 1 | Output enable for the pin |
| tx_end_o | output | 1 | Transmission complete |

## Verification
The bench sweeps every combination of word length, parity and stop count over a range of characters, and sends all 256 characters in the 8N1 format. This catches a shifter that sends MSB first, counts the wrong number of bits, puts the masked seventh bit into the parity, or inverts the parity sense. Two characters are queued back to back, so a sequencer that adds an idle bit, or one that drops the second character, shows up as a misaligned frame. A frame is cut short with the enable: a design that only masks the pin would resume the old frame once enabled again. The bench also drives a break, and a receive error while a character is queued, which exposes a design that lets the character leak out or loses the queued data.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic {TX_IDLE = 1'b0, TX_BUSY = 1'b1} tx_state_e;

  typedef struct packed {
    logic word7;
    logic par_en;
    logic par_odd;
    logic stop2;
  } frame_cfg_t;
endpackage

// File: rtl/uart_tx_buf.sv
module uart_tx_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              load_i,
  output logic [DATA_W-1:0] data_o,
  output logic              empty_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      empty_o <= 1'b1;
    end else if (wr_i) begin
      data_o  <= wdata_i;
      empty_o <= 1'b0;
    end else if (load_i) begin
      empty_o <= 1'b1;
    end
  end

  p_wr_fills_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !empty_o);
  p_load_frees_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !wr_i) |=> empty_o);
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
  import uart_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data_i,
  input  frame_cfg_t         cfg_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [LEN_W-1:0]   len_o
);
  logic [LEN_W-1:0]  n_data;
  logic [LEN_W-1:0]  pos;
  logic [DATA_W-1:0] mask;
  logic              par_bit;

  always_comb begin
    n_data  = cfg_i.word7 ? LEN_W'(DATA_W - 1) : LEN_W'(DATA_W);
    mask    = cfg_i.word7 ? {1'b0, {(DATA_W-1){1'b1}}} : '1;
    par_bit = (^(data_i & mask)) ^ cfg_i.par_odd;
    frame_o = '1;                 // stop bits default to mark
    frame_o[0] = 1'b0;            // start bit
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(n_data)) frame_o[i+1] = data_i[i];
    end
    pos = n_data + LEN_W'(1);
    if (cfg_i.par_en) begin
      frame_o[pos] = par_bit;
      pos = pos + LEN_W'(1);
    end
    len_o = pos + (cfg_i.stop2 ? LEN_W'(2) : LEN_W'(1));
  end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int FRAME_W = 12,
  parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               en_i,
  input  logic               start_ok_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [LEN_W-1:0]   len_i,
  output logic               load_o,
  output logic               line_o,
  output logic               busy_o
);
  tx_state_e          state_q;
  logic [FRAME_W-1:0] sreg_q;
  logic [LEN_W-1:0]   left_q;
  logic               last_bit;

  assign busy_o   = (state_q == TX_BUSY);
  assign last_bit = busy_o && (left_q == LEN_W'(1));
  // a new frame may start from idle or straight out of the last stop bit
  assign load_o   = tick_i && en_i && start_ok_i && (!busy_o || last_bit);
  assign line_o   = busy_o ? sreg_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      sreg_q  <= '1;
      left_q  <= '0;
    end else if (!en_i) begin
      state_q <= TX_IDLE;
      sreg_q  <= '1;
      left_q  <= '0;
    end else if (tick_i) begin
      if (load_o) begin
        state_q <= TX_BUSY;
        sreg_q  <= frame_i;
        left_q  <= len_i;
      end else if (last_bit) begin
        state_q <= TX_IDLE;
        sreg_q  <= '1;
        left_q  <= '0;
      end else if (busy_o) begin
        sreg_q  <= {1'b1, sreg_q[FRAME_W-1:1]};
        left_q  <= left_q - LEN_W'(1);
      end
    end
  end

  p_abort_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !busy_o);
  p_start_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !line_o);
  p_bit_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && en_i && !tick_i) |=> (busy_o && $stable(line_o)));
  p_err_block_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_ok_i) |=> !busy_o);
endmodule

// File: rtl/uart_tx_pin.sv
module uart_tx_pin (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic line_i,
  input  logic wr_i,
  input  logic dir_i,
  input  logic dat_i,
  output logic txd_o,
  output logic oe_o
);
  logic dir_q, dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= 1'b1;
      dat_q <= 1'b1;
    end else if (wr_i) begin
      dir_q <= dir_i;
      dat_q <= dat_i;
    end
  end

  assign txd_o = en_i ? line_i : dat_q;
  assign oe_o  = en_i | dir_q;

  p_port_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && $past(!en_i) && !$past(wr_i)) |-> $stable(txd_o));
  p_port_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !en_i) |=> (!en_i || txd_o == $past(dat_i)));
endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_tick_i,
  input  logic              tx_en_i,
  input  logic              tdr_wr_i,
  input  logic [DATA_W-1:0] tdr_data_i,
  output logic              tdr_empty_o,
  input  logic              word7_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              stop2_i,
  input  logic              port_wr_i,
  input  logic              port_dir_i,
  input  logic              port_dat_i,
  input  logic              rx_err_i,
  output logic              txd_o,
  output logic              txd_oe_o,
  output logic              tx_end_o
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  frame_cfg_t         cfg;
  logic [DATA_W-1:0]  tdr_q;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   frame_len;
  logic               load, line, busy, start_ok;

  assign cfg      = '{word7: word7_i, par_en: par_en_i, par_odd: par_odd_i, stop2: stop2_i};
  assign start_ok = !tdr_empty_o && !rx_err_i;
  assign tx_end_o = !busy && tdr_empty_o;

  uart_tx_buf #(.DATA_W(DATA_W)) u_buf (
    .clk_i, .rst_ni, .wr_i(tdr_wr_i), .wdata_i(tdr_data_i),
    .load_i(load), .data_o(tdr_q), .empty_o(tdr_empty_o)
  );

  uart_tx_frame #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_frame (
    .data_i(tdr_q), .cfg_i(cfg), .frame_o(frame), .len_o(frame_len)
  );

  uart_tx_shift #(.FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_shift (
    .clk_i, .rst_ni, .tick_i(bit_tick_i), .en_i(tx_en_i), .start_ok_i(start_ok),
    .frame_i(frame), .len_i(frame_len), .load_o(load), .line_o(line), .busy_o(busy)
  );

  uart_tx_pin u_pin (
    .clk_i, .rst_ni, .en_i(tx_en_i), .line_i(line), .wr_i(port_wr_i),
    .dir_i(port_dir_i), .dat_i(port_dat_i), .txd_o(txd_o), .oe_o(txd_oe_o)
  );

  p_end_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> !tx_end_o);
  p_no_start_untick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !bit_tick_i) |=> !busy);
endmodule

// File: tb/tb_uart_tx_brk.sv
module tb_uart_tx_brk;
  localparam int TP = 4;

  logic clk = 0, rst_ni = 0;
  logic tick = 0, tx_en = 0, tdr_wr = 0, word7 = 0, par_en = 0, par_odd = 0, stop2 = 0;
  logic port_wr = 0, port_dir = 1, port_dat = 1, rx_err = 0;
  logic [7:0] tdr_data = 0;
  logic txd, oe, tdr_empty, tx_end;

  int checks = 0, errors = 0, tick_cnt = 0, n_lg = 0;
  logic lg [0:2047];
  bit done = 0;

  always #10 clk = ~clk;

  uart_tx_brk dut (
    .clk_i(clk), .rst_ni(rst_ni), .bit_tick_i(tick), .tx_en_i(tx_en),
    .tdr_wr_i(tdr_wr), .tdr_data_i(tdr_data), .tdr_empty_o(tdr_empty),
    .word7_i(word7), .par_en_i(par_en), .par_odd_i(par_odd), .stop2_i(stop2),
    .port_wr_i(port_wr), .port_dir_i(port_dir), .port_dat_i(port_dat),
    .rx_err_i(rx_err), .txd_o(txd), .txd_oe_o(oe), .tx_end_o(tx_end)
  );

  // log the line once per bit period, just after each tick edge
  always @(negedge clk) begin
    if (tick) begin
      if (n_lg < 2048) lg[n_lg] = txd;
      n_lg++;
    end
    tick_cnt = (tick_cnt == TP-1) ? 0 : tick_cnt + 1;
    tick = (tick_cnt == 0);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick_edge();
    do @(posedge clk); while (!tick);
    #2;
  endtask

  task automatic write_tdr(input logic [7:0] d);
    @(negedge clk); tdr_wr = 1; tdr_data = d;
    @(negedge clk); tdr_wr = 0;
  endtask

  task automatic write_port(input logic dir, input logic dat);
    @(negedge clk); port_wr = 1; port_dir = dir; port_dat = dat;
    @(negedge clk); port_wr = 0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 400; k++) begin
      @(posedge clk); #2;
      if (tx_end) break;
    end
    tick_edge(); tick_edge();
  endtask

  function automatic logic [11:0] exp_frame(input logic [7:0] d, output int len);
    int nd = word7 ? 7 : 8;
    int ones = 0;
    logic [11:0] f = '1;
    f[0] = 0;
    for (int i = 0; i < nd; i++) begin f[i+1] = d[i]; ones += d[i]; end
    len = nd + 1;
    if (par_en) begin
      f[len] = (ones % 2 == 1) ? !par_odd : par_odd;
      len++;
    end
    len += stop2 ? 2 : 1;
    return f;
  endfunction

  function automatic int first_low(input int from);
    for (int i = from; i < n_lg; i++) if (lg[i] == 0) return i;
    return -1;
  endfunction

  function automatic logic [11:0] grab(input int s, input int len);
    logic [11:0] g = '1;
    for (int i = 0; i < len; i++) g[i] = (s >= 0 && s + i < n_lg) ? lg[s+i] : 1'bx;
    return g;
  endfunction

  task automatic send_check(input logic [7:0] d, input string req);
    int len, s;
    logic [11:0] e, g;
    n_lg = 0;
    write_tdr(d);
    wait_done();
    e = exp_frame(d, len);
    s = first_low(0);
    g = grab(s, len);
    chk(g === e && (s + len >= n_lg || lg[s+len] == 1), req, {20'd0, g}, {20'd0, e});
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int s, l1, l2;
    logic [11:0] e1, e2;
    bit seen_low;
    repeat (3) @(negedge clk);
    #2;
    // R1 reset state
    chk(txd == 1 && oe == 1 && tdr_empty == 1 && tx_end == 1, "R1", {txd, oe, tdr_empty, tx_end}, 4'hf);
    @(negedge clk); rst_ni = 1;
    @(posedge clk); #2;
    chk(txd == 1 && oe == 1, "R1 port reset", {txd, oe}, 2'b11);

    // R2 pin from port bit while disabled
    write_port(1, 0); #2;
    chk(txd == 0, "R2", txd, 0);
    write_port(1, 1); #2;
    chk(txd == 1, "R2", txd, 1);

    // R3 output enable over dir x en
    for (int c = 0; c < 4; c++) begin
      write_port(c[0], 1);
      @(negedge clk); tx_en = c[1];
      @(posedge clk); #2;
      chk(oe == (c[0] | c[1]), "R3", oe, c[0] | c[1]);
    end
    write_port(1, 1);
    @(negedge clk); tx_en = 1;

    // R8 handshake and start timing
    tick_edge();
    write_tdr(8'h3c); #2;
    chk(tdr_empty == 0 && tx_end == 0, "R8 R10 queued", {tdr_empty, tx_end}, 0);
    for (int k = 0; k < 3; k++) begin
      tick_edge();
      if (txd == 0) break;
    end
    chk(txd == 0 && tdr_empty == 1 && tx_end == 0, "R8 R4 start", {txd, tdr_empty, tx_end}, 3'b010);
    wait_done();
    chk(tx_end == 1, "R10 end", tx_end, 1);

    // R4 exhaustive 8N1
    for (int d = 0; d < 256; d++) send_check(d[7:0], "R4 8N1");

    // R5 R6 R7 format sweep
    for (int c = 0; c < 16; c++) begin
      @(negedge clk); {word7, par_en, par_odd, stop2} = c[3:0];
      foreach (e1[i]) begin end
      send_check(8'h00, "R5 R6 R7");
      send_check(8'hff, "R5 R6 R7");
      send_check(8'ha5, "R5 R6 R7");
      send_check(8'h5a, "R5 R6 R7");
      send_check(8'h80, "R5 R6 R7");
      send_check(8'h01, "R5 R6 R7");
      send_check(8'h7e, "R5 R6 R7");
      send_check(8'hc3, "R5 R6 R7");
    end

    // R9 back-to-back frames (8E2)
    @(negedge clk); {word7, par_en, par_odd, stop2} = 4'b0101;
    n_lg = 0;
    write_tdr(8'h96);
    for (int k = 0; k < 200; k++) begin @(posedge clk); #2; if (tdr_empty) break; end
    write_tdr(8'h2b);
    wait_done();
    e1 = exp_frame(8'h96, l1);
    e2 = exp_frame(8'h2b, l2);
    s = first_low(0);
    chk(grab(s, l1) === e1, "R9 first", grab(s, l1), e1);
    chk(grab(s + l1, l2) === e2, "R9 second", grab(s + l1, l2), e2);

    // R11 abort mid-frame
    @(negedge clk); {word7, par_en, par_odd, stop2} = 4'b0000;
    write_tdr(8'h00);
    for (int k = 0; k < 4; k++) tick_edge();
    chk(txd == 0, "R11 mid-frame low", txd, 0);
    @(negedge clk); tx_en = 0;
    @(posedge clk); #2;
    chk(txd == 1 && tx_end == 1, "R11 abort", {txd, tx_end}, 2'b11);
    @(negedge clk); tx_en = 1;
    n_lg = 0;
    for (int k = 0; k < 15; k++) tick_edge();
    seen_low = 0;
    for (int i = 0; i < n_lg; i++) if (lg[i] == 0) seen_low = 1;
    chk(!seen_low && tx_end == 1, "R11 no resume", {seen_low, tx_end}, 2'b01);

    // R12 break
    write_tdr(8'hff);
    for (int k = 0; k < 3; k++) tick_edge();
    write_port(1, 0);
    @(negedge clk); tx_en = 0;
    for (int k = 0; k < 12; k++) begin
      @(posedge clk); #2;
      if (txd != 0 || oe != 1) break;
    end
    chk(txd == 0 && oe == 1, "R12 break", {txd, oe}, 2'b01);
    write_port(1, 1); #2;
    chk(txd == 1, "R12 release", txd, 1);
    @(negedge clk); tx_en = 1;

    // R13 receive error blocks start
    tick_edge();
    @(negedge clk); rx_err = 1;
    write_tdr(8'h55);
    n_lg = 0;
    for (int k = 0; k < 4; k++) tick_edge();
    seen_low = 0;
    for (int i = 0; i < n_lg; i++) if (lg[i] == 0) seen_low = 1;
    chk(!seen_low && tdr_empty == 0 && tx_end == 0, "R13 blocked", {seen_low, tdr_empty, tx_end}, 0);
    @(negedge clk); rx_err = 0;
    tick_edge();
    chk(txd == 0 && tdr_empty == 1, "R13 released", {txd, tdr_empty}, 2'b01);
    wait_done();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule